// File: doc/BRIEF.md
# Two-Area Bidirectional Mailbox Memory

This block passes bytes between two processors through two separate storage areas, each with one fixed direction of travel. One area is loaded from port A and unloaded from port B; the other is loaded from port B and unloaded from port A. Each port has its own active-low select, write strobe and read strobe, an address whose top bit names the area, and a data bus. The bus is split into an input byte, an output byte and a drive flag that the pad logic outside the block uses to turn the bus around.

The top address bit makes an access legal or illegal. A write that names the wrong area for its port is dropped. A read that names the wrong area still drives the bus, but it carries a fixed filler byte. Both ports run at the same time. If one port writes a word in the same cycle that the other port reads it, the reader sees the new byte in that cycle.

Writes are stored on the rising clock edge. Reads are combinational from storage, with a bypass from the write side.

Top module: `mbx_dual_area`

## Requirements
- R1: A port A write (select low, write strobe low) with address bit 7 = 0 stores its byte at the low 7 address bits of the A-to-B area. A later port B read with bit 7 = 0 at the same low bits returns that byte.
- R2: A port B write with address bit 7 = 1 stores its byte in the B-to-A area. A later port A read with bit 7 = 1 at the same low bits returns that byte.
- R3: A write with an illegal bit 7 stores nothing: 1 on port A, or 0 on port B. The addressed word keeps its earlier value.
- R4: A read happens when select is low, the write strobe is high and the read strobe is low. The drive flag is then 1 and the output carries the stored byte.
- R5: A read with an illegal bit 7 sets the drive flag to 1 and outputs the filler byte (default 8'hA5). That means bit 7 = 0 on port A, or bit 7 = 1 on port B.
- R6: With select low, the write strobe high and the read strobe high, the drive flag is 0 and the output byte is 0.
- R7: With select high, the port neither reads nor writes. Its drive flag is 0, its output byte is 0, and any write strobe is ignored.
- R8: During a write the drive flag is 0 whatever the read strobe is, and the output byte is 0.
- R9: If one port writes a word while the other port reads the same word of that area, the reader's output equals the byte being written in that same cycle. This holds in both directions.
- R10: Reset clears both areas to 0.
- R11: Writes from both ports in the same cycle, one to each area, are both stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes are stored on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_cs_n | input | 1 | Port A select, active low |
| a_we_n | input | 1 | Port A write strobe, active low |
| a_oe_n | input | 1 | Port A read strobe, active low |
| a_addr | input | ADDR_W | Port A address; top bit picks the area |
| a_din | input | DATA_W | Port A write byte |
| a_dout | output | DATA_W | Port A read byte (0 when not driving) |
| a_drive | output | 1 | Port A bus drive flag |
| b_cs_n | input | 1 | Port B select, active low |
| b_we_n | input | 1 | Port B write strobe, active low |
| b_oe_n | input | 1 | Port B read strobe, active low |
| b_addr | input | ADDR_W | Port B address; top bit picks the area |
| b_din | input | DATA_W | Port B write byte |
| b_dout | output | DATA_W | Port B read byte (0 when not driving) |
| b_drive | output | 1 | Port B bus drive flag |

## Verification
The bench aims at the area-select bit. If a design decoded that bit the wrong way round, illegal writes would overwrite words and legal reads would return the filler byte. It drives a same-word write and read in both directions within one cycle. A design without the bypass would show the old byte until the next cycle. It also holds the read strobe low during writes and drops select during write strobes. A design that ignored those qualifiers would turn the bus on while the port is writing, or store bytes from a deselected port.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef struct packed {
    logic sel;
    logic wr;
    logic rd;
    logic wr_ok;
    logic rd_ok;
  } mbx_access_t;

  // Classify one port's strobes; wr_bit is the area bit this port may write.
  function automatic mbx_access_t classify(input logic cs_n, input logic we_n,
                                           input logic oe_n, input logic area_bit,
                                           input logic wr_bit);
    mbx_access_t r;
    r.sel   = ~cs_n;
    r.wr    = ~cs_n & ~we_n;
    r.rd    = ~cs_n & we_n & ~oe_n;
    r.wr_ok = r.wr & (area_bit == wr_bit);
    r.rd_ok = r.rd & (area_bit == ~wr_bit);
    return r;
  endfunction

endpackage

// File: rtl/mbx_area.sv
module mbx_area #(
  parameter int IDX_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              collide
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign collide = wr_en && (wr_idx == rd_idx);
  assign rd_data = collide ? wr_data : mem[rd_idx];
endmodule

// File: rtl/mbx_port_ctl.sv
module mbx_port_ctl
  import mbx_pkg::*;
#(
  parameter int          DATA_W = 8,
  parameter logic        WR_BIT = 1'b0,
  parameter logic [DATA_W-1:0] FILL = 8'hA5
) (
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              area_bit,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_ok,
  output logic              rd_ok,
  output logic [DATA_W-1:0] dout,
  output logic              drive
);
  mbx_access_t acc;

  always_comb begin
    acc   = classify(cs_n, we_n, oe_n, area_bit, WR_BIT);
    wr_ok = acc.wr_ok;
    rd_ok = acc.rd_ok;
    drive = acc.rd & acc.sel;
    if (!drive)      dout = '0;
    else if (rd_ok)  dout = rd_data;
    else             dout = FILL;
  end
endmodule

// File: rtl/mbx_dual_area.sv
module mbx_dual_area #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] FILL = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_cs_n,
  input  logic              a_we_n,
  input  logic              a_oe_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_din,
  output logic [DATA_W-1:0] a_dout,
  output logic              a_drive,
  input  logic              b_cs_n,
  input  logic              b_we_n,
  input  logic              b_oe_n,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_din,
  output logic [DATA_W-1:0] b_dout,
  output logic              b_drive
);
  localparam int IDX_W = ADDR_W - 1;

  logic              a_wr_ok, a_rd_ok, b_wr_ok, b_rd_ok;
  logic [DATA_W-1:0] ab_rd, ba_rd;
  logic              ab_collide, ba_collide;

  mbx_port_ctl #(.DATA_W(DATA_W), .WR_BIT(1'b0), .FILL(FILL)) u_port_a (
    .cs_n(a_cs_n), .we_n(a_we_n), .oe_n(a_oe_n), .area_bit(a_addr[ADDR_W-1]),
    .rd_data(ba_rd), .wr_ok(a_wr_ok), .rd_ok(a_rd_ok),
    .dout(a_dout), .drive(a_drive)
  );

  mbx_port_ctl #(.DATA_W(DATA_W), .WR_BIT(1'b1), .FILL(FILL)) u_port_b (
    .cs_n(b_cs_n), .we_n(b_we_n), .oe_n(b_oe_n), .area_bit(b_addr[ADDR_W-1]),
    .rd_data(ab_rd), .wr_ok(b_wr_ok), .rd_ok(b_rd_ok),
    .dout(b_dout), .drive(b_drive)
  );

  // A-to-B area: written by A, read by B
  mbx_area #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_area_ab (
    .clk(clk), .rst_n(rst_n), .wr_en(a_wr_ok), .wr_idx(a_addr[IDX_W-1:0]),
    .wr_data(a_din), .rd_idx(b_addr[IDX_W-1:0]), .rd_data(ab_rd),
    .collide(ab_collide)
  );

  // B-to-A area: written by B, read by A
  mbx_area #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_area_ba (
    .clk(clk), .rst_n(rst_n), .wr_en(b_wr_ok), .wr_idx(b_addr[IDX_W-1:0]),
    .wr_data(b_din), .rd_idx(a_addr[IDX_W-1:0]), .rd_data(ba_rd),
    .collide(ba_collide)
  );
endmodule

// File: rtl/mbx_dual_area_chk.sv
module mbx_dual_area_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] FILL = 8'hA5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              a_cs_n,
  input logic              a_we_n,
  input logic              a_oe_n,
  input logic [ADDR_W-1:0] a_addr,
  input logic [DATA_W-1:0] a_din,
  input logic [DATA_W-1:0] a_dout,
  input logic              a_drive,
  input logic              b_cs_n,
  input logic              b_we_n,
  input logic              b_oe_n,
  input logic [ADDR_W-1:0] b_addr,
  input logic [DATA_W-1:0] b_din,
  input logic [DATA_W-1:0] b_dout,
  input logic              b_drive,
  input logic              a_wr_ok,
  input logic              b_wr_ok,
  input logic              a_rd_ok,
  input logic              b_rd_ok,
  input logic              ab_collide,
  input logic              ba_collide
);
  localparam int IDX_W = ADDR_W - 1;

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_DESELECT_QUIET_A: assert property (@(posedge clk) disable iff (!rst_n)
    a_cs_n |-> (!a_drive && a_dout == '0)); // R7
  AST_DESELECT_QUIET_B: assert property (@(posedge clk) disable iff (!rst_n)
    b_cs_n |-> (!b_drive && b_dout == '0)); // R7
  AST_WRITE_NO_DRIVE_A: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_cs_n && !a_we_n) |-> !a_drive); // R8
  AST_WRITE_NO_DRIVE_B: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_cs_n && !b_we_n) |-> !b_drive); // R8
  AST_READ_DRIVES_A: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_cs_n && a_we_n && !a_oe_n) |-> a_drive); // R4
  AST_OE_HIGH_FLOAT_B: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_cs_n && b_we_n && b_oe_n) |-> (!b_drive && b_dout == '0)); // R6
  AST_ILLEGAL_READ_FILL_A: assert property (@(posedge clk) disable iff (!rst_n)
    (a_drive && !a_addr[ADDR_W-1]) |-> (a_dout == FILL)); // R5
  AST_ILLEGAL_READ_FILL_B: assert property (@(posedge clk) disable iff (!rst_n)
    (b_drive && b_addr[ADDR_W-1]) |-> (b_dout == FILL)); // R5
  AST_BYPASS_A_TO_B: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_collide && b_rd_ok) |-> (b_dout == a_din)); // R9
  AST_BYPASS_B_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
    (ba_collide && a_rd_ok) |-> (a_dout == b_din)); // R9
  AST_COMMIT_A_TO_B: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && b_rd_ok && $past(a_wr_ok) && !ab_collide &&
     $past(a_addr[IDX_W-1:0]) == b_addr[IDX_W-1:0]) |-> (b_dout == $past(a_din))); // R1
  AST_COMMIT_B_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && a_rd_ok && $past(b_wr_ok) && !ba_collide &&
     $past(b_addr[IDX_W-1:0]) == a_addr[IDX_W-1:0]) |-> (a_dout == $past(b_din))); // R2
endmodule

bind mbx_dual_area mbx_dual_area_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FILL(FILL)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_cs_n(a_cs_n), .a_we_n(a_we_n), .a_oe_n(a_oe_n), .a_addr(a_addr),
  .a_din(a_din), .a_dout(a_dout), .a_drive(a_drive),
  .b_cs_n(b_cs_n), .b_we_n(b_we_n), .b_oe_n(b_oe_n), .b_addr(b_addr),
  .b_din(b_din), .b_dout(b_dout), .b_drive(b_drive),
  .a_wr_ok(a_wr_ok), .b_wr_ok(b_wr_ok), .a_rd_ok(a_rd_ok), .b_rd_ok(b_rd_ok),
  .ab_collide(ab_collide), .ba_collide(ba_collide)
);

// File: tb/tb_mbx_dual_area.sv
module tb_mbx_dual_area;
  localparam logic [7:0] FILLV = 8'hA5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       a_cs_n = 1'b1, a_we_n = 1'b1, a_oe_n = 1'b1;
  logic [7:0] a_addr = '0, a_din = '0;
  logic [7:0] a_dout;
  logic       a_drive;
  logic       b_cs_n = 1'b1, b_we_n = 1'b1, b_oe_n = 1'b1;
  logic [7:0] b_addr = '0, b_din = '0;
  logic [7:0] b_dout;
  logic       b_drive;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  mbx_dual_area dut (
    .clk(clk), .rst_n(rst_n),
    .a_cs_n(a_cs_n), .a_we_n(a_we_n), .a_oe_n(a_oe_n), .a_addr(a_addr),
    .a_din(a_din), .a_dout(a_dout), .a_drive(a_drive),
    .b_cs_n(b_cs_n), .b_we_n(b_we_n), .b_oe_n(b_oe_n), .b_addr(b_addr),
    .b_din(b_din), .b_dout(b_dout), .b_drive(b_drive)
  );

  task automatic chk(input string req, input string what,
                     input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got {drive,data}=%h expected %h", req, what, act, exp);
    end
  endtask

  // set a port's strobes: cs, we, oe, address, data
  task automatic set_a(input logic cs, input logic we, input logic oe,
                       input logic [7:0] ad, input logic [7:0] d);
    a_cs_n = cs; a_we_n = we; a_oe_n = oe; a_addr = ad; a_din = d;
  endtask
  task automatic set_b(input logic cs, input logic we, input logic oe,
                       input logic [7:0] ad, input logic [7:0] d);
    b_cs_n = cs; b_we_n = we; b_oe_n = oe; b_addr = ad; b_din = d;
  endtask

  // move to the next cycle's driving point
  task automatic step;
    @(negedge clk);
  endtask

  task automatic idle_both;
    set_a(1, 1, 1, 8'h00, 8'h00);
    set_b(1, 1, 1, 8'h00, 8'h00);
  endtask

  task automatic t_reset;
    step; idle_both; #1;
    chk("R7", "A idle after reset", {a_drive, a_dout}, 9'h000);
    chk("R7", "B idle after reset", {b_drive, b_dout}, 9'h000);
    set_b(0, 1, 0, 8'h05, 8'h00); #1;
    chk("R10", "A-to-B word cleared", {b_drive, b_dout}, {1'b1, 8'h00});
    set_a(0, 1, 0, 8'hFF, 8'h00); #1;
    chk("R10", "B-to-A word cleared", {a_drive, a_dout}, {1'b1, 8'h00});
  endtask

  task automatic t_a_to_b;
    step; idle_both; set_a(0, 0, 1, 8'h05, 8'h3C);
    step; idle_both; set_a(0, 0, 1, 8'h7F, 8'h81);
    step; idle_both; set_b(0, 1, 0, 8'h05, 8'h00); #1;
    chk("R1", "B reads A's word 05", {b_drive, b_dout}, {1'b1, 8'h3C});
    set_b(0, 1, 0, 8'h7F, 8'h00); #1;
    chk("R4", "B reads top word 7F", {b_drive, b_dout}, {1'b1, 8'h81});
  endtask

  task automatic t_b_to_a;
    step; idle_both; set_b(0, 0, 1, 8'h85, 8'hC3);
    step; idle_both; set_a(0, 1, 0, 8'h85, 8'h00); #1;
    chk("R2", "A reads B's word 85", {a_drive, a_dout}, {1'b1, 8'hC3});
  endtask

  task automatic t_illegal_write;
    step; idle_both; set_a(0, 0, 1, 8'h85, 8'hFF); set_b(0, 0, 1, 8'h05, 8'h11);
    step; idle_both; set_a(0, 1, 0, 8'h85, 8'h00); set_b(0, 1, 0, 8'h05, 8'h00); #1;
    chk("R3", "A write to bit7=1 dropped", {a_drive, a_dout}, {1'b1, 8'hC3});
    chk("R3", "B write to bit7=0 dropped", {b_drive, b_dout}, {1'b1, 8'h3C});
  endtask

  task automatic t_illegal_read;
    step; idle_both; set_a(0, 1, 0, 8'h05, 8'h00); set_b(0, 1, 0, 8'h85, 8'h00); #1;
    chk("R5", "A read bit7=0 gives filler", {a_drive, a_dout}, {1'b1, FILLV});
    chk("R5", "B read bit7=1 gives filler", {b_drive, b_dout}, {1'b1, FILLV});
  endtask

  task automatic t_oe_high;
    step; idle_both; set_a(0, 1, 1, 8'h85, 8'h00); set_b(0, 1, 1, 8'h05, 8'h00); #1;
    chk("R6", "A read strobe high floats", {a_drive, a_dout}, 9'h000);
    chk("R6", "B read strobe high floats", {b_drive, b_dout}, 9'h000);
  endtask

  task automatic t_deselect;
    step; idle_both; set_a(1, 0, 0, 8'h05, 8'h77); set_b(1, 0, 0, 8'h85, 8'h66); #1;
    chk("R7", "A deselected no drive", {a_drive, a_dout}, 9'h000);
    chk("R7", "B deselected no drive", {b_drive, b_dout}, 9'h000);
    step; idle_both; set_b(0, 1, 0, 8'h05, 8'h00); set_a(0, 1, 0, 8'h85, 8'h00); #1;
    chk("R7", "deselected A write ignored", {b_drive, b_dout}, {1'b1, 8'h3C});
    chk("R7", "deselected B write ignored", {a_drive, a_dout}, {1'b1, 8'hC3});
  endtask

  task automatic t_write_no_drive;
    step; idle_both; set_a(0, 0, 0, 8'h06, 8'h42); set_b(0, 0, 0, 8'h86, 8'h24); #1;
    chk("R8", "A write with read strobe low", {a_drive, a_dout}, 9'h000);
    chk("R8", "B write with read strobe low", {b_drive, b_dout}, 9'h000);
    step; idle_both; set_b(0, 1, 0, 8'h06, 8'h00); set_a(0, 1, 0, 8'h86, 8'h00); #1;
    chk("R8", "A write stored", {b_drive, b_dout}, {1'b1, 8'h42});
    chk("R8", "B write stored", {a_drive, a_dout}, {1'b1, 8'h24});
  endtask

  task automatic t_collision;
    step; idle_both; set_a(0, 0, 1, 8'h10, 8'h99); set_b(0, 1, 0, 8'h10, 8'h00); #1;
    chk("R9", "B sees A's write same cycle", {b_drive, b_dout}, {1'b1, 8'h99});
    step; idle_both; set_b(0, 0, 1, 8'h90, 8'h66); set_a(0, 1, 0, 8'h90, 8'h00); #1;
    chk("R9", "A sees B's write same cycle", {a_drive, a_dout}, {1'b1, 8'h66});
    step; idle_both; set_b(0, 1, 0, 8'h10, 8'h00); set_a(0, 1, 0, 8'h90, 8'h00); #1;
    chk("R9", "A-to-B collision word kept", {b_drive, b_dout}, {1'b1, 8'h99});
    chk("R9", "B-to-A collision word kept", {a_drive, a_dout}, {1'b1, 8'h66});
  endtask

  task automatic t_both_write;
    step; idle_both; set_a(0, 0, 1, 8'h20, 8'h12); set_b(0, 0, 1, 8'hA0, 8'h34);
    step; idle_both; set_b(0, 1, 0, 8'h20, 8'h00); set_a(0, 1, 0, 8'hA0, 8'h00); #1;
    chk("R11", "A's write in dual cycle", {b_drive, b_dout}, {1'b1, 8'h12});
    chk("R11", "B's write in dual cycle", {a_drive, a_dout}, {1'b1, 8'h34});
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_a_to_b;
    t_b_to_a;
    t_illegal_write;
    t_illegal_read;
    t_oe_high;
    t_deselect;
    t_write_no_drive;
    t_collision;
    t_both_write;
    step; idle_both;
    step;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule